// File: doc/BRIEF.md
# Interlocked Stall Pipeline

A chain of identical synchronous stages that moves a data word and its valid bit forward by one stage per clock, with a stall signal that travels the other way. Each stage registers the stall it gives to its predecessor. A stall therefore climbs back toward the input by exactly one stage per clock edge, and no combinational ready path runs the length of the chain.

Because a predecessor sees the stall one cycle late, every stage has a second storage slot. The word that arrives in that extra cycle lands in the second slot. A stage that holds no valid word drops an incoming stall and does not forward it, so bubbles soak up stall pressure. Every slot also drives a load-enable output, which stands in for a clock-gate enable. An enable is high only when its slot captures a valid word and the stage is allowed to take it.

Top module: `ilk_pipe`

## Requirements
- R1: While `rst_ni` is low, and on an idle pipeline after reset, `out_valid_o`, `in_stall_o` and every bit of `slot_ld_en_o` are 0.
- R2: With `out_stall_i` held low, one word is accepted per cycle. A word accepted at a clock edge shows on `out_valid_o`/`out_data_o` exactly `NUM_STAGES` cycles later.
- R3: A word is accepted when `in_valid_i` is high and `in_stall_o` is low at a clock edge. It is consumed when `out_valid_o` is high and `out_stall_i` is low. For any pattern of `in_valid_i` and `out_stall_i`, every accepted word is consumed exactly once, in acceptance order.
- R4: On a full pipeline fed every cycle, `out_stall_i` may rise and stay high. `in_stall_o` then rises exactly `NUM_STAGES` clock edges later.
- R5: In the situation of R4, exactly `NUM_STAGES` further words are accepted after `out_stall_i` rises. The chain then holds `2*NUM_STAGES` words and loses none of them.
- R6: A stage without a valid word does not forward stall. With an empty pipeline, or with a single word parked at the output under `out_stall_i`, `in_stall_o` stays 0.
- R7: A stage's main slot does not load while it holds a valid word and its downstream stall is high. Its second slot does not load while the stage's own stall is high. A full, fully stalled chain has `slot_ld_en_o` all 0.
- R8: Bit `2k` of `slot_ld_en_o` is the main slot of stage `k` (stage 0 at the input) and bit `2k+1` is its second slot. A bit is high only when that slot captures a valid word. Stage 0 loads at most one of its slots per cycle.
- R9: If `out_valid_o` is high and `out_stall_i` is high, then in the next cycle `out_valid_o` is still high and `out_data_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Upstream word is valid |
| in_data_i | input | DATA_W | Upstream word |
| in_stall_o | output | 1 | Registered stall to upstream |
| out_valid_o | output | 1 | Downstream word is valid |
| out_data_o | output | DATA_W | Downstream word |
| out_stall_i | input | 1 | Stall from downstream |
| slot_ld_en_o | output | 2*NUM_STAGES | Per-slot load enable (clock-gate model) |

## Verification
An unbroken stream with no stall fixes the latency and the one-per-cycle rate. A full stream hit by a held stall counts the cycles until the input sees it and the extra words taken in, which shows whether the stall really climbs one stage per edge and whether the second slots absorb the lag. A single word stalled at the output separates a stall that is dropped in empty stages from one that wrongly reaches the input. A long pseudo-random mix of valid and stall is checked against an ordered scoreboard, and it exposes lost, duplicated or reordered words.

// File: rtl/ilk_pkg.sv
`timescale 1ns/1ps
package ilk_pkg;
  localparam int SLOTS_PER_STAGE = 2;
  localparam int SLOT_MAIN       = 0;
  localparam int SLOT_SKID       = 1;
endpackage

// File: rtl/ilk_slot.sv
`timescale 1ns/1ps
module ilk_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              vld_nx_i,
  input  logic [DATA_W-1:0] d_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] d_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_nx_i;
  end

  // data needs no reset; only written on a gated load
  always_ff @(posedge clk_i) begin
    if (ld_i) d_o <= d_i;
  end
endmodule

// File: rtl/ilk_stage.sv
`timescale 1ns/1ps
module ilk_stage
  import ilk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  input  logic [DATA_W-1:0]          in_data_i,
  input  logic                       stall_i,
  output logic                       valid_o,
  output logic [DATA_W-1:0]          data_o,
  output logic                       stall_o,
  output logic [SLOTS_PER_STAGE-1:0] ld_en_o
);
  logic              main_v, skid_v, stall_q;
  logic [DATA_W-1:0] skid_d, main_in_d;
  logic              out_go, main_from_in, main_from_skid, skid_from_in;
  logic              main_v_nx, skid_v_nx, stall_nx;

  always_comb begin
    out_go         = main_v & ~stall_i;
    main_from_in   = ~stall_q & in_valid_i & (~main_v | out_go);
    skid_from_in   = ~stall_q & in_valid_i & main_v & ~out_go;
    main_from_skid = stall_q & skid_v & out_go;

    if (main_from_in | main_from_skid) main_v_nx = 1'b1;
    else if (out_go)                   main_v_nx = 1'b0;
    else                               main_v_nx = main_v;

    if (skid_from_in)        skid_v_nx = 1'b1;
    else if (main_from_skid) skid_v_nx = 1'b0;
    else                     skid_v_nx = skid_v;

    // decision folded into the register input: stall only with valid data held
    stall_nx  = skid_v_nx | (main_v_nx & stall_i);
    main_in_d = main_from_skid ? skid_d : in_data_i;
  end

  ilk_slot #(.DATA_W(DATA_W)) u_main (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (main_from_in | main_from_skid),
    .vld_nx_i (main_v_nx),
    .d_i      (main_in_d),
    .vld_o    (main_v),
    .d_o      (data_o)
  );

  ilk_slot #(.DATA_W(DATA_W)) u_skid (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (skid_from_in),
    .vld_nx_i (skid_v_nx),
    .d_i      (in_data_i),
    .vld_o    (skid_v),
    .d_o      (skid_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= stall_nx;
  end

  assign valid_o            = main_v;
  assign stall_o            = stall_q;
  assign ld_en_o[SLOT_MAIN] = main_from_in | main_from_skid;
  assign ld_en_o[SLOT_SKID] = skid_from_in;
endmodule

// File: rtl/ilk_pipe.sv
`timescale 1ns/1ps
module ilk_pipe
  import ilk_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int DATA_W     = 16
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  in_valid_i,
  input  logic [DATA_W-1:0]                     in_data_i,
  output logic                                  in_stall_o,
  output logic                                  out_valid_o,
  output logic [DATA_W-1:0]                     out_data_o,
  input  logic                                  out_stall_i,
  output logic [NUM_STAGES*SLOTS_PER_STAGE-1:0] slot_ld_en_o
);
  logic [NUM_STAGES:0]             vld_w;
  logic [NUM_STAGES:0]             stl_w;
  logic [NUM_STAGES:0][DATA_W-1:0] dat_w;

  assign vld_w[0]          = in_valid_i;
  assign dat_w[0]          = in_data_i;
  assign stl_w[NUM_STAGES] = out_stall_i;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    ilk_stage #(.DATA_W(DATA_W)) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_valid_i (vld_w[k]),
      .in_data_i  (dat_w[k]),
      .stall_i    (stl_w[k+1]),
      .valid_o    (vld_w[k+1]),
      .data_o     (dat_w[k+1]),
      .stall_o    (stl_w[k]),
      .ld_en_o    (slot_ld_en_o[k*SLOTS_PER_STAGE +: SLOTS_PER_STAGE])
    );
  end

  assign in_stall_o  = stl_w[0];
  assign out_valid_o = vld_w[NUM_STAGES];
  assign out_data_o  = dat_w[NUM_STAGES];
endmodule

// File: rtl/ilk_pipe_chk.sv
`timescale 1ns/1ps
module ilk_pipe_chk #(
  parameter int NUM_STAGES = 4,
  parameter int DATA_W     = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic                    in_stall_o,
  input logic                    out_valid_o,
  input logic [DATA_W-1:0]       out_data_o,
  input logic                    out_stall_i,
  input logic [2*NUM_STAGES-1:0] slot_ld_en_o
);
  localparam int LAST_MAIN = 2 * (NUM_STAGES - 1);

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_stall_i |=> out_valid_o && $stable(out_data_o)); // R9

  AST_LAST_MAIN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_stall_i |-> !slot_ld_en_o[LAST_MAIN]); // R7

  AST_FRONT_SKID_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_stall_o |-> !slot_ld_en_o[1]); // R7

  AST_FRONT_SKID_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_ld_en_o[1] |-> in_valid_i); // R8

  AST_FRONT_ONE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_ld_en_o[1:0])); // R8
endmodule

bind ilk_pipe ilk_pipe_chk #(.NUM_STAGES(NUM_STAGES), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/ilk_pipe_tb.sv
`timescale 1ns/1ps
module ilk_pipe_tb;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int SB = 4096;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic [DW-1:0]   in_data_i = '0;
  logic            in_stall_o;
  logic            out_valid_o;
  logic [DW-1:0]   out_data_o;
  logic            out_stall_i = 1'b0;
  logic [2*N-1:0]  slot_ld_en_o;

  ilk_pipe #(.NUM_STAGES(N), .DATA_W(DW)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_data_i    (in_data_i),
    .in_stall_o   (in_stall_o),
    .out_valid_o  (out_valid_o),
    .out_data_o   (out_data_o),
    .out_stall_i  (out_stall_i),
    .slot_ld_en_o (slot_ld_en_o)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int wr    = 0;
  int rd    = 0;
  logic [DW-1:0] sb_d [SB];
  int            sb_t [SB];
  bit            lat_on = 0;
  logic          acc_seen, istall_seen;
  logic [2*N-1:0] ld_seen;
  logic [DW-1:0] seq = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive, sample before the next rising edge, score transfers
  task automatic tick(input logic v, input logic [DW-1:0] d, input logic st);
    @(negedge clk);
    in_valid_i  = v;
    in_data_i   = d;
    out_stall_i = st;
    #1;
    cyc++;
    istall_seen = in_stall_o;
    ld_seen     = slot_ld_en_o;
    acc_seen    = v && !in_stall_o && rst_ni;
    if (acc_seen) begin
      sb_d[wr % SB] = d;
      sb_t[wr % SB] = cyc;
      wr++;
    end
    if (rst_ni && out_valid_o && !st) begin
      if (rd == wr) chk(0, "R3 extra word", longint'(out_data_o), -1);
      else begin
        chk(out_data_o == sb_d[rd % SB], "R3 order", longint'(out_data_o), longint'(sb_d[rd % SB]));
        if (lat_on) chk(cyc - sb_t[rd % SB] == N, "R2 latency", cyc - sb_t[rd % SB], N);
        rd++;
      end
    end
  endtask

  task automatic feed(input logic v, input logic st);
    tick(v, seq, st);
    if (acc_seen) seq++;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    wr = 0; rd = 0;
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, '0, 1'b0);
      chk(out_valid_o == 0 && in_stall_o == 0, "R1 in reset", {out_valid_o, in_stall_o}, 0);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    tick(1'b0, '0, 1'b0);
    chk(ld_seen == 0 && out_valid_o == 0 && in_stall_o == 0, "R1 idle", longint'(ld_seen), 0);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, '0, 1'b0);
    chk(wr == rd, "R3 nothing lost", wr - rd, 0);
  endtask

  task automatic t_stream();
    t_reset();
    lat_on = 1;
    for (int i = 0; i < 20; i++) begin
      feed(1'b1, 1'b0);
      if (i == 0) chk(ld_seen == 1, "R8 first load bit", longint'(ld_seen), 1);
      if (i == 1) chk(ld_seen == 5, "R8 main bits", longint'(ld_seen), 5);
      chk(!istall_seen, "R2 no stall while streaming", istall_seen, 0);
    end
    drain(N + 2);
    lat_on = 0;
  endtask

  task automatic t_stall_fill();
    int acc = 0;
    int first_st = -1;
    t_reset();
    for (int i = 0; i < N + 2; i++) feed(1'b1, 1'b0);
    for (int j = 0; j < 3 * N; j++) begin
      feed(1'b1, 1'b1);
      if (acc_seen) acc++;
      if (istall_seen && first_st < 0) first_st = j;
      if (j == N - 1) chk(ld_seen == 2, "R8 front second slot only", longint'(ld_seen), 2);
      if (j == N + 2) chk(ld_seen == 0, "R7 all gated", longint'(ld_seen), 0);
    end
    chk(first_st == N, "R4 stall reach", first_st, N);
    chk(acc == N, "R5 extra accepted", acc, N);
    chk(wr - rd == 2 * N, "R5 words held", wr - rd, 2 * N);
    drain(3 * N);
  endtask

  task automatic t_lone();
    logic [DW-1:0] held;
    t_reset();
    for (int i = 0; i < 2; i++) begin
      tick(1'b0, '0, 1'b1);
      chk(!istall_seen, "R6 empty ignores stall", istall_seen, 0);
    end
    tick(1'b1, 16'hA5C3, 1'b1);
    for (int j = 1; j <= 3 * N; j++) begin
      tick(1'b0, '0, 1'b1);
      chk(!istall_seen, "R6 lone word no stall", istall_seen, 0);
      if (j == N) held = out_data_o;
    end
    chk(out_valid_o && out_data_o == 16'hA5C3 && held == 16'hA5C3, "R9 held word",
        longint'(out_data_o), 16'hA5C3);
    drain(N);
  endtask

  task automatic t_random();
    logic [15:0] lfsr = 16'hACE1;
    t_reset();
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      feed(lfsr[0] | lfsr[3], (i % 200 < 100) ? (lfsr[5] & lfsr[7]) : (lfsr[2] | lfsr[9]));
    end
    drain(4 * N);
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_stream();
    t_stall_fill();
    t_lone();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule